// File: doc/BRIEF.md
# Multi-Word Flash Program Staging Buffer

This block collects up to four 32-bit words in staging slots and writes them into a flash array, one after another, from a single trigger. Each slot has a fill flag. Software sets the flag by writing the slot. The flag clears when the word in that slot has been accepted by the array. While an operation runs, software can write slots that have already been drained. The engine then keeps going around the ring of slots until it finds an empty one. A read-only register shows the address of the word being programmed. After the operation ends, it keeps the last address that was programmed.

Software reaches the block through a simple register bus. Each write is one cycle with `bus_wen` high. Reads are combinational on `bus_addr`. The flash side is a valid/ready stream. Once `fl_valid` is high, it stays high and `fl_addr` and `fl_data` do not change until the array asserts `fl_ready`. A word counts as transferred only in a cycle where both signals are high. The array may hold `fl_ready` low for any number of cycles. Erase, verification and permission checks are done elsewhere, before the trigger.

Register indices: 0 is the single-word data register, which shares its storage with slot 0. Indices 1 to 4 are slots 0 to 3. Index 5 is the start address. Index 6 is the trigger on write and the status on read. Index 7 is the live address, which is read-only.

Top module: `mwp_buffer`

## Requirements
- R1: After reset, all fill flags, busy and active are 0, `fl_valid` is 0, and the live address, start address and slot registers all read 0.
- R2: Writing slot index 1..4 stores the data and sets that slot's flag. The status read at index 6 has busy in bit 0, active in bit 1 and the flags of slots 0..3 in bits 2..5. All other bits read 0.
- R3: Index 0 and index 1 write and read the same storage. A write through either one sets the flag of slot 0.
- R4: A write to index 6 with bit 0 set, while idle and with start address bits [1:0] equal to 0, sets busy at the next clock edge. Active rises one cycle after busy. A trigger with a misaligned start address is ignored.
- R5: Words go out in slot order 0, 1, 2, 3 and then wrap to 0. The first address is the start address, and each following address is 4 higher than the one before.
- R6: A slot's flag clears on the transfer of its word. `fl_valid`, `fl_addr` and `fl_data` stay unchanged while `fl_ready` is low.
- R7: When the next slot's flag is clear, the operation ends, and busy and active fall in the same cycle. A trigger when no flag is set ends without any transfer.
- R8: While active, the live address equals the address being offered. After the end, it holds the last address that was programmed.
- R9: During an operation, a write to a slot that is not being offered is accepted. A write to the slot being offered changes neither its data nor its flag.
- R10: Writes to the start address while busy are ignored.
- R11: A write to the next slot in the same cycle as the current word's transfer is seen by the engine, and the operation continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| fl_valid | output | 1 | A word is offered to the flash array |
| fl_ready | input | 1 | The array accepts the offered word |
| fl_addr | output | 32 | Flash address of the offered word |
| fl_data | output | 32 | Offered word |

## Verification
Two functions can fall in the same cycle: the array's acceptance of the current word, and a software write that refills the slot the engine will check next. The bench raises `fl_ready` and writes the next slot on the same clock edge, with that slot empty beforehand. It passes only if a second transfer follows at the next address, and none follows when the refill is left out. A second collision is a write to the slot being offered. The bench judges it by reading that slot back and by the data the array finally receives.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_CHECK = 2'd2,
    ST_SEND  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/mwp_slots.sv
module mwp_slots #(
  parameter int N_SLOTS = 4,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_SLOTS-1:0]               wr_en_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic [N_SLOTS-1:0]               lock_i,
  input  logic [N_SLOTS-1:0]               clr_i,
  output logic [N_SLOTS-1:0][DATA_W-1:0]   data_o,
  output logic [N_SLOTS-1:0]               flag_o
);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic take;
    assign take = wr_en_i[i] && !lock_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[i] <= '0;
        flag_o[i] <= 1'b0;
      end else begin
        if (take) data_o[i] <= wr_data_i;
        if (clr_i[i])  flag_o[i] <= 1'b0;
        else if (take) flag_o[i] <= 1'b1;
      end
    end

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[i] |=> !flag_o[i]);  // R6
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i[i] && !clr_i[i]) |=> $stable(data_o[i]) && $stable(flag_o[i]));  // R9
  end

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));  // R6

endmodule

// File: rtl/mwp_engine.sv
module mwp_engine
  import mwp_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             go_i,
  input  logic [ADDR_W-1:0]                start_i,
  input  logic [N_SLOTS-1:0]               flag_i,
  input  logic [N_SLOTS-1:0][DATA_W-1:0]   data_i,
  output logic                             busy_o,
  output logic                             active_o,
  output logic [N_SLOTS-1:0]               clr_o,
  output logic [N_SLOTS-1:0]               lock_o,
  output logic [ADDR_W-1:0]                live_o,
  output logic                             fl_valid,
  input  logic                             fl_ready,
  output logic [ADDR_W-1:0]                fl_addr,
  output logic [DATA_W-1:0]                fl_data
);

  localparam int PTR_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(N_SLOTS - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(DATA_W / 8);

  eng_state_t       state;
  logic [PTR_W-1:0] ptr;
  logic [ADDR_W-1:0] next_addr;
  logic             xfer;

  assign fl_valid = (state == ST_SEND);
  assign fl_addr  = live_o;
  assign fl_data  = data_i[ptr];
  assign xfer     = fl_valid && fl_ready;
  assign active_o = (state == ST_CHECK) || (state == ST_SEND);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_sel
    assign lock_o[i] = fl_valid && (ptr == PTR_W'(i));
    assign clr_o[i]  = xfer && (ptr == PTR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      busy_o    <= 1'b0;
      ptr       <= '0;
      next_addr <= '0;
      live_o    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go_i) begin
            busy_o <= 1'b1;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          next_addr <= start_i;
          ptr       <= '0;
          state     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (flag_i[ptr]) begin
            live_o <= next_addr;
            state  <= ST_SEND;
          end else begin
            busy_o <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        ST_SEND: begin
          if (fl_ready) begin
            next_addr <= next_addr + STEP;
            ptr       <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
            state     <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> fl_valid && $stable(fl_addr) && $stable(fl_data));  // R6
  AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> busy_o);  // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer ##2 fl_valid) |-> fl_addr == $past(fl_addr, 2) + STEP);  // R5

endmodule

// File: rtl/mwp_regif.sv
module mwp_regif #(
  parameter int N_SLOTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_wen,
  input  logic [REG_AW-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  output logic [DATA_W-1:0]                bus_rdata,
  input  logic                             busy_i,
  input  logic                             active_i,
  input  logic [N_SLOTS-1:0]               flag_i,
  input  logic [N_SLOTS-1:0][DATA_W-1:0]   data_i,
  input  logic [ADDR_W-1:0]                live_i,
  output logic [N_SLOTS-1:0]               slot_wr_o,
  output logic [ADDR_W-1:0]                start_o,
  output logic                             go_o
);

  localparam int ALIGN_W = $clog2(DATA_W / 8);
  localparam logic [REG_AW-1:0] IDX_SINGLE = '0;
  localparam logic [REG_AW-1:0] IDX_START  = REG_AW'(N_SLOTS + 1);
  localparam logic [REG_AW-1:0] IDX_CTRL   = REG_AW'(N_SLOTS + 2);
  localparam logic [REG_AW-1:0] IDX_LIVE   = REG_AW'(N_SLOTS + 3);
  localparam int STAT_W = N_SLOTS + 2;

  logic aligned;
  assign aligned = (start_o[ALIGN_W-1:0] == '0);
  assign go_o    = bus_wen && (bus_addr == IDX_CTRL) && bus_wdata[0] && !busy_i && aligned;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_dec
    if (i == 0) begin : g_first
      assign slot_wr_o[i] = bus_wen && ((bus_addr == REG_AW'(1)) || (bus_addr == IDX_SINGLE));
    end else begin : g_rest
      assign slot_wr_o[i] = bus_wen && (bus_addr == REG_AW'(i + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_o <= '0;
    else if (bus_wen && (bus_addr == IDX_START) && !busy_i) start_o <= bus_wdata[ADDR_W-1:0];
  end

  logic [STAT_W-1:0] status;
  assign status = {flag_i, active_i, busy_i};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == IDX_SINGLE)     bus_rdata = data_i[0];
    else if (bus_addr == IDX_START) bus_rdata = DATA_W'(start_o);
    else if (bus_addr == IDX_CTRL)  bus_rdata = DATA_W'(status);
    else if (bus_addr == IDX_LIVE)  bus_rdata = DATA_W'(live_i);
    else begin
      for (int k = 0; k < N_SLOTS; k++) begin
        if (bus_addr == REG_AW'(k + 1)) bus_rdata = data_i[k];
      end
    end
  end

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(start_o));  // R10

endmodule

// File: rtl/mwp_buffer.sv
module mwp_buffer #(
  parameter int N_SLOTS = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int REG_AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_data
);

  localparam int ALIGN_W = $clog2(DATA_W / 8);

  logic                           busy, active, go;
  logic [N_SLOTS-1:0]             flags, slot_wr, lock, clr;
  logic [N_SLOTS-1:0][DATA_W-1:0] slot_data;
  logic [ADDR_W-1:0]              start_addr, live_addr;

  mwp_regif #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(busy), .active_i(active), .flag_i(flags), .data_i(slot_data), .live_i(live_addr),
    .slot_wr_o(slot_wr), .start_o(start_addr), .go_o(go)
  );

  mwp_slots #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(slot_wr), .wr_data_i(bus_wdata), .lock_i(lock), .clr_i(clr),
    .data_o(slot_data), .flag_o(flags)
  );

  mwp_engine #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .go_i(go), .start_i(start_addr), .flag_i(flags), .data_i(slot_data),
    .busy_o(busy), .active_o(active), .clr_o(clr), .lock_o(lock), .live_o(live_addr),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_addr(fl_addr), .fl_data(fl_data)
  );

  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy && !active);  // R4
  AST_END_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(active));  // R7
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> (fl_addr[ALIGN_W-1:0] == '0));  // R4

endmodule

// File: tb/tb_mwp_buffer.sv
module tb_mwp_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fl_valid, fl_ready = 1'b0;
  logic [31:0] fl_addr, fl_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] cap_a [64];
  logic [31:0] cap_d [64];
  int cap_n = 0;

  always #10 clk = ~clk;

  mwp_buffer dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_valid(fl_valid),
    .fl_ready(fl_ready), .fl_addr(fl_addr), .fl_data(fl_data)
  );

  always @(posedge clk) begin
    if (rst_n && fl_valid && fl_ready && cap_n < 64) begin
      cap_a[cap_n] <= fl_addr;
      cap_d[cap_n] <= fl_data;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = idx; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] v);
    bus_addr = idx;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rd(3'd6, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (fl_valid) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd6, v); chk(v == 32'h0, "R1 status", v, 32'h0);
    rd(3'd7, v); chk(v == 32'h0, "R1 live", v, 32'h0);
    rd(3'd5, v); chk(v == 32'h0, "R1 start", v, 32'h0);
    rd(3'd3, v); chk(v == 32'h0, "R1 slot", v, 32'h0);
    chk(fl_valid == 1'b0, "R1 fl_valid", 32'(fl_valid), 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    int b;
    wr(3'd5, 32'h100);
    for (int i = 0; i < 4; i++) wr(3'(i + 1), 32'hA000_0000 + 32'(i));
    rd(3'd6, v); chk(v == 32'h3C, "R2 status flags", v, 32'h3C);
    rd(3'd2, v); chk(v == 32'hA000_0001, "R2 slot readback", v, 32'hA000_0001);
    fl_ready = 1'b1;
    b = cap_n;
    wr(3'd6, 32'h1);
    rd(3'd6, v); chk(v[1:0] == 2'b01, "R4 busy before active", v, 32'h3D);
    @(negedge clk);
    rd(3'd6, v); chk(v[1:0] == 2'b11, "R4 active follows", v, 32'h3F);
    wait_idle();
    chk(cap_n - b == 4, "R7 word count", 32'(cap_n - b), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk(cap_a[b + i] == 32'h100 + 32'(4 * i), "R5 address", cap_a[b + i], 32'h100 + 32'(4 * i));
      chk(cap_d[b + i] == 32'hA000_0000 + 32'(i), "R5 order", cap_d[b + i], 32'hA000_0000 + 32'(i));
    end
    rd(3'd6, v); chk(v == 32'h0, "R6 flags cleared", v, 32'h0);
    rd(3'd7, v); chk(v == 32'h10C, "R8 last address", v, 32'h10C);
  endtask

  task automatic t_mirror();
    logic [31:0] v;
    wr(3'd0, 32'h5555_AAAA);
    rd(3'd1, v); chk(v == 32'h5555_AAAA, "R3 single to slot0", v, 32'h5555_AAAA);
    rd(3'd6, v); chk(v == 32'h4, "R3 flag0 set", v, 32'h4);
    wr(3'd1, 32'h1234_5678);
    rd(3'd0, v); chk(v == 32'h1234_5678, "R3 slot0 to single", v, 32'h1234_5678);
  endtask

  task automatic t_misaligned();
    logic [31:0] v;
    int b;
    b = cap_n;
    wr(3'd5, 32'h102);
    wr(3'd6, 32'h1);
    repeat (3) @(negedge clk);
    rd(3'd6, v); chk(v == 32'h4, "R4 misaligned ignored", v, 32'h4);
    chk(cap_n == b, "R4 no transfer", 32'(cap_n - b), 32'd0);
  endtask

  task automatic t_refill_wrap();
    logic [31:0] v, a0;
    int b;
    fl_ready = 1'b0;
    wr(3'd5, 32'h200);
    for (int i = 0; i < 4; i++) wr(3'(i + 1), 32'hB000_0000 + 32'(i));
    b = cap_n;
    wr(3'd6, 32'h1);
    wait_valid();
    a0 = fl_addr;
    repeat (3) @(negedge clk);
    chk(fl_valid && fl_addr == a0, "R6 hold under back-pressure", fl_addr, a0);
    wr(3'd1, 32'hDEAD_0000);
    rd(3'd1, v); chk(v == 32'hB000_0000, "R9 offered slot write ignored", v, 32'hB000_0000);
    wr(3'd5, 32'h7FC);
    @(negedge clk); fl_ready = 1'b1;
    @(negedge clk); fl_ready = 1'b0;
    wait_valid();
    rd(3'd7, v); chk(v == fl_addr && v == 32'h204, "R8 live tracks offer", v, 32'h204);
    wr(3'd1, 32'hC0DE_0000);
    rd(3'd6, v); chk(v[2] == 1'b1, "R9 refill accepted", v, 32'h4);
    fl_ready = 1'b1;
    wait_idle();
    chk(cap_n - b == 5, "R5 wrap count", 32'(cap_n - b), 32'd5);
    chk(cap_d[b] == 32'hB000_0000, "R9 offered word unchanged", cap_d[b], 32'hB000_0000);
    chk(cap_a[b + 4] == 32'h210, "R5 wrap address", cap_a[b + 4], 32'h210);
    chk(cap_d[b + 4] == 32'hC0DE_0000, "R5 wrap data", cap_d[b + 4], 32'hC0DE_0000);
    rd(3'd5, v); chk(v == 32'h200, "R10 start held", v, 32'h200);
    rd(3'd7, v); chk(v == 32'h210, "R8 last after wrap", v, 32'h210);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    int b;
    fl_ready = 1'b0;
    wr(3'd5, 32'h300);
    wr(3'd1, 32'hE000_0000);
    b = cap_n;
    wr(3'd6, 32'h1);
    wait_valid();
    fl_ready = 1'b1;
    bus_wen = 1'b1; bus_addr = 3'd2; bus_wdata = 32'hE000_0001;
    @(negedge clk);
    bus_wen = 1'b0;
    wait_idle();
    chk(cap_n - b == 2, "R11 refill in transfer cycle", 32'(cap_n - b), 32'd2);
    chk(cap_a[b + 1] == 32'h304, "R11 second address", cap_a[b + 1], 32'h304);
    chk(cap_d[b + 1] == 32'hE000_0001, "R11 second data", cap_d[b + 1], 32'hE000_0001);
    wr(3'd5, 32'h400);
    wr(3'd1, 32'hF000_0000);
    b = cap_n;
    wr(3'd6, 32'h1);
    wait_idle();
    chk(cap_n - b == 1, "R7 stop without refill", 32'(cap_n - b), 32'd1);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    int b;
    b = cap_n;
    wr(3'd6, 32'h1);
    @(negedge clk);
    rd(3'd6, v); chk(v == 32'h3, "R7 empty check", v, 32'h3);
    @(negedge clk);
    rd(3'd6, v); chk(v == 32'h0, "R7 busy and active drop", v, 32'h0);
    chk(cap_n == b, "R7 empty no transfer", 32'(cap_n - b), 32'd0);
    rd(3'd7, v); chk(v == 32'h400, "R8 live kept", v, 32'h400);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mirror();
    t_misaligned();
    t_refill_wrap();
    t_collision();
    t_empty();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule